// File: doc/BRIEF.md
# Halfword Instruction Fetch Buffer

This block sits between a processor fetch stage and a word-wide instruction memory port. It keeps one aligned memory block (a 32-bit word by default, or a 64-bit doubleword when the bus parameter is widened) together with the address tag of that block. While the core keeps asking for instructions that lie inside the held block, each one is delivered in the same cycle it is requested, and no memory access takes place. The number of instructions served per memory access is therefore the bus width divided by the instruction width. With the defaults (32-bit bus, 16-bit instructions) that is two.

A request outside the held block starts one read of the aligned block that contains it. The low address bits are cleared, so a jump into the second halfword still brings in the whole word. When the data returns, the block adds a programmable number of wait states (0 to 3) before the new instructions become available. A redirect input, raised on a taken branch, empties the buffer. A fill that is still outstanding when the redirect arrives is dropped. Two counters report the number of memory requests and the number of cycles the core spent waiting. Together they let a cycle-count formula be checked from outside the block.

Top module: `hw_fetch_buf`

## Requirements
- R1: After reset, `req_count` and `stall_count` are zero, `core_ready` and `mem_req` are low while `core_req` is low, and the buffer holds nothing, so the first request always goes to memory.
- R2: A request whose address lies in the buffered aligned block is accepted in the same cycle (`core_ready` high), with no `mem_req` and no change to `req_count`.
- R3: With 16-bit instructions on a 32-bit bus, the instruction is taken in big-endian order. Address bit 1 = 0 selects data bits [31:16] of the buffered word, and bit 1 = 1 selects bits [15:0]. Request addresses are instruction-aligned.
- R4: A request that misses raises `mem_req` for exactly one cycle, in the first cycle of the request. `mem_addr` equals the request address with its low log2(bus bytes) bits cleared.
- R5: The memory answers with `mem_valid` one cycle after `mem_req`, and `wait_cfg` (0..3) is sampled when the data arrives. Under those conditions a missed request is accepted exactly 2 + `wait_cfg` cycles after its first cycle. Later requests to the same block hit.
- R6: A one-cycle pulse on `redirect` while idle empties the buffer, so the next request to the previously held block misses and reads memory again.
- R7: A `redirect` that arrives while a fill is outstanding discards the returned data. The held request then reads memory a second time, taking 2 × (2 + `wait_cfg`) cycles in total and two memory requests.
- R8: `req_count` increases by one in the cycle after every `mem_req` cycle and is otherwise unchanged.
- R9: `stall_count` increases by one after every cycle in which `core_req` is high and `core_ready` is low.
- R10: No new `mem_req` is raised while a previous request has not yet returned `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_cfg | input | WAIT_W | Wait states added after each memory read (0..3) |
| redirect | input | 1 | Taken-branch pulse; empties the buffer |
| core_req | input | 1 | Core requests the instruction at `core_addr` |
| core_addr | input | ADDR_W | Byte address of the requested instruction |
| core_ready | output | 1 | Request accepted this cycle; `core_insn` is valid |
| core_insn | output | INSN_W | Selected instruction |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Aligned block address of the read |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | BUS_W | Memory read data, lowest address in the top bits |
| req_count | output | CNT_W | Number of memory requests issued |
| stall_count | output | CNT_W | Number of cycles the core waited |

## Verification
The checks assume that the core holds `core_req` and `core_addr` steady until `core_ready`, and that every request address is instruction-aligned. They also assume that memory returns exactly one `mem_valid` per `mem_req`, never before that request. The bench memory model always answers in the cycle after the request. The driver changes the address only after an accepted request and never raises `redirect` in a cycle where a request could be accepted. Wait-state values change only between requests, so each miss sees one setting.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_MEM  = 2'd1,
    FS_HOLD = 2'd2
  } fill_st_t;
endpackage

// File: rtl/hfb_block_tag.sv
module hfb_block_tag #(
  parameter int TAG_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             redirect,
  input  logic             fill_ok,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (redirect) begin
      valid_q <= 1'b0;
    end else if (fill_ok) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag;
    end
  end

  assign hit = valid_q && (tag_q == look_tag);
endmodule

// File: rtl/hfb_lane_sel.sv
module hfb_lane_sel #(
  parameter int BUS_W  = 32,
  parameter int INSN_W = 16,
  localparam int K     = BUS_W / INSN_W,
  localparam int IDX_W = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [BUS_W-1:0]  fill_data,
  input  logic [IDX_W-1:0]  lane_idx,
  output logic [INSN_W-1:0] insn
);
  logic [BUS_W-1:0]  blk_q;
  logic [INSN_W-1:0] lanes [K];

  always_ff @(posedge clk) begin
    if (rst) blk_q <= '0;
    else if (fill_en) blk_q <= fill_data;
  end

  // lane 0 holds the lowest address and sits in the top bits
  for (genvar g = 0; g < K; g++) begin : g_lane
    assign lanes[g] = blk_q[BUS_W-1-g*INSN_W -: INSN_W];
  end

  if (K > 1) begin : g_multi
    assign insn = lanes[lane_idx];
  end else begin : g_single
    assign insn = lanes[0];
  end
endmodule

// File: rtl/hfb_fill_ctrl.sv
module hfb_fill_ctrl
  import hfb_pkg::*;
#(
  parameter int TAG_W  = 30,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              hit,
  input  logic              redirect,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              mem_valid,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              idle,
  output logic              mem_req,
  output logic              fill_en,
  output logic              fill_ok,
  output logic [TAG_W-1:0]  fill_tag
);
  fill_st_t          st_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              kill_q;
  logic [TAG_W-1:0]  tag_q;

  assign idle     = (st_q == FS_IDLE);
  assign mem_req  = idle && core_req && !hit && !redirect;
  assign fill_en  = (st_q == FS_MEM) && mem_valid;
  assign fill_ok  = fill_en && !kill_q;
  assign fill_tag = tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      kill_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      case (st_q)
        FS_IDLE: begin
          if (mem_req) begin
            st_q   <= FS_MEM;
            tag_q  <= look_tag;
            kill_q <= 1'b0;
          end
        end
        FS_MEM: begin
          if (redirect) kill_q <= 1'b1;
          if (mem_valid) begin
            if (wait_cfg == '0) begin
              st_q <= FS_IDLE;
            end else begin
              st_q  <= FS_HOLD;
              cnt_q <= wait_cfg;
            end
          end
        end
        FS_HOLD: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == WAIT_W'(1)) st_q <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hfb_counters.sv
module hfb_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mem_req,
  input  logic             stall,
  output logic [CNT_W-1:0] req_count,
  output logic [CNT_W-1:0] stall_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_count   <= '0;
      stall_count <= '0;
    end else begin
      if (mem_req) req_count <= req_count + 1'b1;
      if (stall) stall_count <= stall_count + 1'b1;
    end
  end
endmodule

// File: rtl/hw_fetch_buf.sv
module hw_fetch_buf #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32,
  parameter int INSN_W = 16,
  parameter int WAIT_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              redirect,
  input  logic              core_req,
  input  logic [ADDR_W-1:0] core_addr,
  output logic              core_ready,
  output logic [INSN_W-1:0] core_insn,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic [CNT_W-1:0]  req_count,
  output logic [CNT_W-1:0]  stall_count
);
  localparam int K     = BUS_W / INSN_W;
  localparam int OFF   = $clog2(BUS_W / 8);
  localparam int ISH   = $clog2(INSN_W / 8);
  localparam int TAG_W = ADDR_W - OFF;
  localparam int IDX_W = (K > 1) ? $clog2(K) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFF) - ADDR_W'(1));

  logic             hit, idle, fill_en, fill_ok;
  logic [TAG_W-1:0] look_tag, fill_tag;
  logic [IDX_W-1:0] lane_idx;

  assign look_tag = core_addr[ADDR_W-1:OFF];
  assign mem_addr = core_addr & ALIGN_MASK;

  if (K > 1) begin : g_idx
    assign lane_idx = core_addr[OFF-1:ISH];
  end else begin : g_noidx
    assign lane_idx = '0;
  end

  assign core_ready = idle && core_req && hit && !redirect;

  hfb_block_tag #(.TAG_W(TAG_W)) u_tag (
    .clk(clk), .rst(rst), .redirect(redirect), .fill_ok(fill_ok),
    .fill_tag(fill_tag), .look_tag(look_tag), .hit(hit)
  );

  hfb_lane_sel #(.BUS_W(BUS_W), .INSN_W(INSN_W)) u_sel (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_data(mem_rdata),
    .lane_idx(lane_idx), .insn(core_insn)
  );

  hfb_fill_ctrl #(.TAG_W(TAG_W), .WAIT_W(WAIT_W)) u_ctl (
    .clk(clk), .rst(rst), .core_req(core_req), .hit(hit), .redirect(redirect),
    .wait_cfg(wait_cfg), .mem_valid(mem_valid), .look_tag(look_tag),
    .idle(idle), .mem_req(mem_req), .fill_en(fill_en), .fill_ok(fill_ok),
    .fill_tag(fill_tag)
  );

  hfb_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .mem_req(mem_req), .stall(core_req && !core_ready),
    .req_count(req_count), .stall_count(stall_count)
  );
endmodule

// File: rtl/hfb_checker.sv
module hfb_checker #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              core_req,
  input logic [ADDR_W-1:0] core_addr,
  input logic              core_ready,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [CNT_W-1:0]  req_count,
  input logic [CNT_W-1:0]  stall_count
);
  localparam int ISH = (INSN_W > 8) ? $clog2(INSN_W / 8) : 1;
  logic outst_q;

  always_ff @(posedge clk) begin
    if (rst) outst_q <= 1'b0;
    else if (mem_req) outst_q <= 1'b1;
    else if (mem_valid) outst_q <= 1'b0;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (req_count == '0 && stall_count == '0)); // R1
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> !mem_req); // R2
  AST_ADDR_ALIGNED_IN: assert property (@(posedge clk) disable iff (rst)
    core_req |-> (core_addr[ISH-1:0] == '0)); // R3
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R4
  AST_REQ_COUNT_INC: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> (req_count == CNT_W'($past(req_count) + 1'b1))); // R8
  AST_REQ_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mem_req |=> $stable(req_count)); // R8
  AST_STALL_COUNT_INC: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_ready) |=> (stall_count == CNT_W'($past(stall_count) + 1'b1))); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !outst_q); // R10
endmodule

bind hw_fetch_buf hfb_checker #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .core_req(core_req), .core_addr(core_addr),
  .core_ready(core_ready), .mem_req(mem_req), .mem_valid(mem_valid),
  .req_count(req_count), .stall_count(stall_count)
);

// File: tb/tb_hw_fetch_buf.sv
`timescale 1ns/1ps
module tb_hw_fetch_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wait_cfg = 2'd0;
  logic        redirect = 1'b0;
  logic        core_req = 1'b0;
  logic [31:0] core_addr = '0;
  logic        core_ready;
  logic [15:0] core_insn;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;
  logic [15:0] req_count, stall_count;

  int errors = 0, checks = 0;
  int tot_reqs = 0, tot_stall = 0, overlaps = 0;
  bit outst = 0;
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;

  hw_fetch_buf dut (
    .clk(clk), .rst(rst), .wait_cfg(wait_cfg), .redirect(redirect),
    .core_req(core_req), .core_addr(core_addr), .core_ready(core_ready),
    .core_insn(core_insn), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .req_count(req_count), .stall_count(stall_count)
  );

  function automatic logic [15:0] hw_at(input logic [31:0] a);
    logic [31:0] v;
    v = (a >> 1) * 32'd3 + 32'h1111;
    return v[15:0] ^ 16'hA5C3;
  endfunction

  // memory model: answers the cycle after a request, lowest address in top half
  always @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_valid <= mem_req;
      if (mem_req) mem_rdata <= {hw_at(mem_addr), hw_at(mem_addr + 32'd2)};
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: scoreboard pops on every accepted request
  always @(negedge clk) begin
    if (!rst) begin
      if (core_req && core_ready) begin
        if (exp_q.size() == 0) check(0, "R2", "unexpected transfer", core_insn, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(core_insn == e, "R3", "instruction", core_insn, e);
        end
      end
      if (mem_req) begin
        check(mem_addr == {core_addr[31:2], 2'b00}, "R4", "aligned memory address",
              mem_addr, {core_addr[31:2], 2'b00});
        if (outst) overlaps++;
        outst = 1;
      end else if (mem_valid) outst = 0;
    end
  end

  task automatic fetch(input logic [31:0] a, input int exp_lat, input int exp_reqs,
                       input int redir_at, input string rq);
    int lat;
    logic [15:0] rc0, sc0;
    @(posedge clk); #1;
    core_req = 1'b1;
    core_addr = a;
    exp_q.push_back(hw_at(a));
    rc0 = req_count;
    sc0 = stall_count;
    lat = 0;
    forever begin
      @(negedge clk);
      redirect = 1'b0;
      if (core_ready) break;
      if (lat == redir_at) redirect = 1'b1;
      lat++;
    end
    check(lat == exp_lat, rq, "latency", lat, exp_lat);
    check(int'(req_count - rc0) == exp_reqs, rq, "memory requests",
          req_count - rc0, exp_reqs);
    check(int'(stall_count - sc0) == lat, "R9", "stall delta", stall_count - sc0, lat);
    tot_reqs += exp_reqs;
    tot_stall += exp_lat;
    @(posedge clk); #1;
    core_req = 1'b0;
  endtask

  task automatic pulse_redirect();
    @(posedge clk); #1 redirect = 1'b1;
    @(posedge clk); #1 redirect = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(core_ready == 1'b0, "R1", "ready after reset", core_ready, 0);
    check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    check(req_count == 0, "R1", "req_count after reset", req_count, 0);
    check(stall_count == 0, "R1", "stall_count after reset", stall_count, 0);

    wait_cfg = 2'd0;
    fetch(32'h100, 2, 1, -1, "R1");   // empty buffer misses
    fetch(32'h102, 0, 0, -1, "R2");   // lower half, hit
    fetch(32'h100, 0, 0, -1, "R2");   // upper half, hit

    wait_cfg = 2'd3;
    fetch(32'h206, 5, 1, -1, "R5");   // branch into second halfword
    fetch(32'h204, 0, 0, -1, "R2");

    wait_cfg = 2'd1;
    fetch(32'h300, 3, 1, -1, "R5");

    wait_cfg = 2'd2;
    fetch(32'h408, 4, 1, -1, "R5");
    pulse_redirect();
    fetch(32'h40A, 4, 1, -1, "R6");   // same block, buffer emptied

    wait_cfg = 2'd1;
    fetch(32'h500, 6, 2, 1, "R7");    // redirect during fill
    fetch(32'h502, 0, 0, -1, "R2");
    fetch(32'h500, 0, 0, -1, "R2");

    wait_cfg = 2'd0;
    fetch(32'h600, 2, 1, -1, "R5");
    fetch(32'h602, 0, 0, -1, "R3");

    @(negedge clk);
    check(int'(req_count) == tot_reqs, "R8", "total requests", req_count, tot_reqs);
    check(int'(stall_count) == tot_stall, "R9", "total stall cycles", stall_count, tot_stall);
    check(overlaps == 0, "R10", "overlapping requests", overlaps, 0);
    check(exp_q.size() == 0, "R2", "pending expected items", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule